// File: doc/BRIEF.md
# Multithreaded Outstanding Miss Tracker

This block keeps the book of cache misses that have been sent to the next memory level and have not yet come back. It serves several hardware threads. Each thread owns one small associative table for read-type misses and one for write-type misses, and every entry is keyed by line address. A requester presents a thread, a request kind, a byte address and a prefetch marker. The block answers with a combinational ready. It forwards every newly allocated miss, with its line-aligned address, to a downstream issue port after a fixed pipeline delay.

When the next level answers, it presents a line address and whether the answer is for a write. The block frees the matching entry and reports which thread and kind completed and how many cycles the miss took. Prefetches complete without a response to the requester and raise a separate pulse. A periodic watchdog looks at the age of every live entry and raises a sticky flag when any entry has waited for the threshold or longer. Live demand, prefetch and total entries are counted and driven out.

Top module: `ot_miss_tracker`

## Requirements
- R1: After reset, req_ready is 1, all three counters are 0, and proto_err, deadlock, rsp_valid, pf_retire and iss_valid are all 0.
- R2: req_kind encodes load=0, instruction fetch=1, store=2, atomic=3. Codes 2 and 3 use the write table of the thread and codes 0 and 1 use its read table. A completion with cpl_write=1 matches only write tables, and one with cpl_write=0 matches only read tables.
- R3: req_ready is 1 only when all of these hold. The total count is below MAX_OUT. No table other than the requester's own table of the request's kind holds the line. That own table either holds the line or has a free slot. No completion for the same line is presented in that cycle.
- R4: An accepted request whose line is already held in the requester's own table of the same kind overwrites that entry's kind, prefetch marker and timestamp. It leaves the total count unchanged and issues nothing downstream.
- R5: A request that allocates a new entry appears on the issue port FWD_LAT cycles after the accepting clock edge. The port carries the address with the low log2(LINE_BYTES) bits cleared, the thread, and iss_write=1 for kinds 2 and 3.
- R6: A completion that matches a demand entry frees that entry. One cycle later it drives rsp_valid for one cycle, with the entry's thread and kind, and with rsp_latency equal to the number of clock edges from the accepting edge to the completing edge.
- R7: A completion that matches a prefetch entry frees it and pulses pf_retire with the same latency and thread fields, and rsp_valid stays 0.
- R8: A completion with no matching entry changes no entry and no counter, and sets proto_err, which stays 1 until reset.
- R9: cnt_demand plus cnt_pf always equals cnt_total. When a new entry is allocated in the same cycle that another entry is freed, cnt_total is unchanged.
- R10: deadlock becomes 1, and stays 1 until reset, after a watchdog check finds a live entry whose age is at least DL_THRESH cycles. It stays 0 when every entry is freed within DL_THRESH cycles of its last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_thread | input | TID_W | Requesting thread |
| req_kind | input | 2 | Request kind (R2 encoding) |
| req_addr | input | ADDR_W | Byte address |
| req_pf | input | 1 | Request is a prefetch |
| req_ready | output | 1 | Request can be accepted this cycle |
| iss_valid | output | 1 | Downstream miss issue |
| iss_addr | output | ADDR_W | Line-aligned miss address |
| iss_thread | output | TID_W | Thread of the issued miss |
| iss_write | output | 1 | Issued miss is a write-type miss |
| cpl_valid | input | 1 | Completion present |
| cpl_line | input | LINE_W | Completed line address |
| cpl_write | input | 1 | Completion is for a write-type miss |
| rsp_valid | output | 1 | Demand miss finished |
| pf_retire | output | 1 | Prefetch miss finished silently |
| rsp_thread | output | TID_W | Thread of the finished entry |
| rsp_kind | output | 2 | Kind of the finished entry |
| rsp_latency | output | TS_W | Miss latency in cycles |
| cnt_total | output | CNT_W | Live entries |
| cnt_demand | output | CNT_W | Live demand entries |
| cnt_pf | output | CNT_W | Live prefetch entries |
| proto_err | output | 1 | Sticky unmatched-completion flag |
| deadlock | output | 1 | Sticky aged-entry flag |

## Verification
The hardest state to reach from the ports is one where several limits bind at once. That means a per-thread table full while the global count is still below its limit, an overwrite that flips a demand entry to a prefetch, and a completion that frees one entry in the same edge as another is allocated. The random phase draws from only ten lines, four kinds and two threads. It mostly completes entries that are really live, so these collisions keep recurring. Directed sequences then pin down the overwrite, the global limit, the silent prefetch, the unmatched completion and both outcomes of the watchdog.

// File: rtl/ot_pkg.sv
package ot_pkg;

    typedef enum logic [1:0] {
        K_LOAD   = 2'd0,
        K_IFETCH = 2'd1,
        K_STORE  = 2'd2,
        K_ATOMIC = 2'd3
    } req_kind_e;

    // store and atomic live in the write table
    function automatic logic kind_is_write(input logic [1:0] k);
        return k[1];
    endfunction

    function automatic logic [15:0] span_at_least(input logic [15:0] age,
                                                  input logic [15:0] lim);
        return {15'd0, age >= lim};
    endfunction

endpackage

// File: rtl/ot_table.sv
module ot_table #(
    parameter int N_ENT  = 4,
    parameter int LINE_W = 12,
    parameter int TS_W   = 16,
    parameter int THRESH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TS_W-1:0]   now,
    input  logic [LINE_W-1:0] q_line,
    output logic              q_hit,
    output logic              q_pf,
    output logic              q_full,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic              wr_pf,
    input  logic [LINE_W-1:0] c_line,
    output logic              c_hit,
    output logic [1:0]        c_kind,
    output logic              c_pf,
    output logic [TS_W-1:0]   c_age,
    input  logic              rt_en,
    output logic              stale
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
        logic [1:0]        kind;
        logic              pf;
        logic [TS_W-1:0]   ts;
    } ent_t;

    ent_t ent [N_ENT];

    logic [IDX_W-1:0] q_idx, free_idx, c_idx;
    logic             have_free;

    always_comb begin
        q_hit = 1'b0; q_idx = '0; q_pf = 1'b0;
        have_free = 1'b0; free_idx = '0;
        c_hit = 1'b0; c_idx = '0;
        stale = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (ent[i].vld && ent[i].line == q_line && !q_hit) begin
                q_hit = 1'b1;
                q_idx = IDX_W'(i);
                q_pf  = ent[i].pf;
            end
            if (!ent[i].vld && !have_free) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
            if (ent[i].vld && ent[i].line == c_line && !c_hit) begin
                c_hit = 1'b1;
                c_idx = IDX_W'(i);
            end
            if (ent[i].vld && (now - ent[i].ts) >= TS_W'(THRESH))
                stale = 1'b1;
        end
        q_full = !have_free;
        c_kind = ent[c_idx].kind;
        c_pf   = ent[c_idx].pf;
        c_age  = now - ent[c_idx].ts;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) ent[i].vld <= 1'b0;
        end else begin
            if (rt_en) ent[c_idx].vld <= 1'b0;
            if (wr_en) begin
                if (q_hit) ent[q_idx] <= '{vld: 1'b1, line: q_line, kind: wr_kind,
                                           pf: wr_pf, ts: now};
                else       ent[free_idx] <= '{vld: 1'b1, line: q_line, kind: wr_kind,
                                              pf: wr_pf, ts: now};
            end
        end
    end

endmodule

// File: rtl/ot_issue_pipe.sv
module ot_issue_pipe #(
    parameter int DEPTH = 2,
    parameter int W     = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic         v [DEPTH];
    logic [W-1:0] d [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) v[0] <= 1'b0;
                else     v[0] <= in_valid;
                d[0] <= in_data;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) v[s] <= 1'b0;
                else     v[s] <= v[s-1];
                d[s] <= d[s-1];
            end
        end
    end

    assign out_valid = v[DEPTH-1];
    assign out_data  = d[DEPTH-1];

endmodule

// File: rtl/ot_watchdog.sv
module ot_watchdog #(
    parameter int THRESH = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_req,
    input  logic busy,
    input  logic stale_any,
    output logic deadlock
);
    localparam int TMR_W = $clog2(THRESH + 1);

    logic             armed;
    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            tmr      <= '0;
            deadlock <= 1'b0;
        end else if (!armed) begin
            tmr <= '0;
            if (arm_req) armed <= 1'b1;
        end else if (tmr == TMR_W'(THRESH - 1)) begin
            tmr <= '0;
            if (stale_any) deadlock <= 1'b1;
            if (!busy)     armed    <= 1'b0;
        end else begin
            tmr <= tmr + TMR_W'(1);
        end
    end

endmodule

// File: rtl/ot_miss_tracker.sv
module ot_miss_tracker
    import ot_pkg::*;
#(
    parameter int N_THR      = 2,   // at least 2
    parameter int N_ENT      = 4,
    parameter int LINE_BYTES = 16,
    parameter int ADDR_W     = 16,
    parameter int MAX_OUT    = 6,
    parameter int TS_W       = 16,
    parameter int DL_THRESH  = 64,
    parameter int FWD_LAT    = 2,
    localparam int TID_W     = $clog2(N_THR),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W,
    localparam int CNT_W     = $clog2(MAX_OUT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [TID_W-1:0]  req_thread,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_pf,
    output logic              req_ready,
    output logic              iss_valid,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [TID_W-1:0]  iss_thread,
    output logic              iss_write,
    input  logic              cpl_valid,
    input  logic [LINE_W-1:0] cpl_line,
    input  logic              cpl_write,
    output logic              rsp_valid,
    output logic              pf_retire,
    output logic [TID_W-1:0]  rsp_thread,
    output logic [1:0]        rsp_kind,
    output logic [TS_W-1:0]   rsp_latency,
    output logic [CNT_W-1:0]  cnt_total,
    output logic [CNT_W-1:0]  cnt_demand,
    output logic [CNT_W-1:0]  cnt_pf,
    output logic              proto_err,
    output logic              deadlock
);
    localparam int N_TBL = 2 * N_THR;
    localparam int TBL_W = TID_W + 1;
    localparam int PW    = TID_W + 1 + LINE_W;

    logic [TS_W-1:0]   now;
    logic [LINE_W-1:0] req_line;
    logic              is_wr;

    logic [N_TBL-1:0]  q_hit, q_pf, q_full, c_hit, c_pf, stale, own_oh;
    logic [N_TBL-1:0]  tbl_wr, tbl_rt;
    logic [1:0]        c_kind [N_TBL];
    logic [TS_W-1:0]   c_age  [N_TBL];

    assign req_line = req_addr[ADDR_W-1:OFF_W];
    assign is_wr    = kind_is_write(req_kind);

    // one read table and one write table per thread: index = 2*thread + write
    for (genvar i = 0; i < N_TBL; i++) begin : g_tbl
        assign own_oh[i] = (req_thread == TID_W'(i / 2)) && (is_wr == 1'(i % 2));
        ot_table #(
            .N_ENT(N_ENT), .LINE_W(LINE_W), .TS_W(TS_W), .THRESH(DL_THRESH)
        ) u_tbl (
            .clk(clk), .rst(rst), .now(now),
            .q_line(req_line), .q_hit(q_hit[i]), .q_pf(q_pf[i]), .q_full(q_full[i]),
            .wr_en(tbl_wr[i]), .wr_kind(req_kind), .wr_pf(req_pf),
            .c_line(cpl_line), .c_hit(c_hit[i]), .c_kind(c_kind[i]), .c_pf(c_pf[i]),
            .c_age(c_age[i]), .rt_en(tbl_rt[i]), .stale(stale[i])
        );
    end

    // admission
    logic conflict, same, own_full, old_pf, cpl_clash, acc, new_alloc, ovw;
    assign conflict  = |(q_hit & ~own_oh);
    assign same      = |(q_hit & own_oh);
    assign own_full  = |(q_full & own_oh);
    assign old_pf    = |(q_pf & q_hit & own_oh);
    assign cpl_clash = cpl_valid && (cpl_line == req_line);
    assign req_ready = (cnt_total < CNT_W'(MAX_OUT)) && !conflict
                       && (same || !own_full) && !cpl_clash;
    assign acc       = req_valid && req_ready;
    assign new_alloc = acc && !same;
    assign ovw       = acc && same;
    assign tbl_wr    = acc ? own_oh : '0;

    // completion: admission allows one live entry per line, so the first
    // table of the right kind that matches is the only one
    logic             found;
    logic [TBL_W-1:0] pick;
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N_TBL; i++) begin
            if (!found && c_hit[i] && ((i % 2) == int'(cpl_write))) begin
                found = 1'b1;
                pick  = TBL_W'(i);
            end
        end
    end

    logic ret, ret_pf;
    assign ret    = cpl_valid && found;
    assign ret_pf = c_pf[pick];
    assign tbl_rt = ret ? (N_TBL'(1) << pick) : '0;

    // counters
    logic [CNT_W-1:0] tot_n, pf_n, dem_n;
    always_comb begin
        tot_n = cnt_total;
        pf_n  = cnt_pf;
        dem_n = cnt_demand;
        if (new_alloc)                   tot_n = tot_n + CNT_W'(1);
        if (ret)                         tot_n = tot_n - CNT_W'(1);
        if (new_alloc && req_pf)         pf_n  = pf_n + CNT_W'(1);
        if (new_alloc && !req_pf)        dem_n = dem_n + CNT_W'(1);
        if (ovw && req_pf && !old_pf) begin
            pf_n  = pf_n + CNT_W'(1);
            dem_n = dem_n - CNT_W'(1);
        end
        if (ovw && !req_pf && old_pf) begin
            pf_n  = pf_n - CNT_W'(1);
            dem_n = dem_n + CNT_W'(1);
        end
        if (ret && ret_pf)               pf_n  = pf_n - CNT_W'(1);
        if (ret && !ret_pf)              dem_n = dem_n - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            now         <= '0;
            cnt_total   <= '0;
            cnt_pf      <= '0;
            cnt_demand  <= '0;
            rsp_valid   <= 1'b0;
            pf_retire   <= 1'b0;
            rsp_thread  <= '0;
            rsp_kind    <= '0;
            rsp_latency <= '0;
            proto_err   <= 1'b0;
        end else begin
            now        <= now + TS_W'(1);
            cnt_total  <= tot_n;
            cnt_pf     <= pf_n;
            cnt_demand <= dem_n;
            rsp_valid  <= ret && !ret_pf;
            pf_retire  <= ret && ret_pf;
            if (ret) begin
                rsp_thread  <= TID_W'(pick >> 1);
                rsp_kind    <= c_kind[pick];
                rsp_latency <= c_age[pick];
            end
            if (cpl_valid && !found) proto_err <= 1'b1;
        end
    end

    // downstream issue
    logic [PW-1:0] iss_data;
    ot_issue_pipe #(.DEPTH(FWD_LAT), .W(PW)) u_iss (
        .clk(clk), .rst(rst),
        .in_valid(new_alloc), .in_data({req_thread, is_wr, req_line}),
        .out_valid(iss_valid), .out_data(iss_data)
    );
    assign iss_thread = iss_data[PW-1 -: TID_W];
    assign iss_write  = iss_data[LINE_W];
    assign iss_addr   = {iss_data[LINE_W-1:0], {OFF_W{1'b0}}};

    ot_watchdog #(.THRESH(DL_THRESH)) u_wd (
        .clk(clk), .rst(rst),
        .arm_req(acc), .busy((cnt_total != '0) || acc),
        .stale_any(|stale), .deadlock(deadlock)
    );

endmodule

// File: rtl/ot_miss_tracker_chk.sv
module ot_miss_tracker_chk #(
    parameter int MAX_OUT = 6,
    parameter int CNT_W   = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [CNT_W-1:0] cnt_total,
    input logic [CNT_W-1:0] cnt_demand,
    input logic [CNT_W-1:0] cnt_pf,
    input logic             rsp_valid,
    input logic             pf_retire,
    input logic             proto_err,
    input logic             deadlock
);
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (cnt_total == '0 && !proto_err && !deadlock && !rsp_valid));

    p_accept_below_max_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> (cnt_total < CNT_W'(MAX_OUT)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_total <= CNT_W'(MAX_OUT));

    p_silent_pf_r7: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && pf_retire));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    p_count_sum_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_demand + cnt_pf) == cnt_total);

    p_dl_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        deadlock |=> deadlock);

endmodule

bind ot_miss_tracker ot_miss_tracker_chk #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .cnt_total(cnt_total), .cnt_demand(cnt_demand), .cnt_pf(cnt_pf),
    .rsp_valid(rsp_valid), .pf_retire(pf_retire),
    .proto_err(proto_err), .deadlock(deadlock)
);

// File: tb/ot_miss_tracker_tb_top.sv
module ot_miss_tracker_tb_top;
    localparam int N_THR = 2, N_ENT = 4, LB = 16, ADDR_W = 16, MAX_OUT = 6;
    localparam int TS_W = 16, DL = 64, FWD = 2;
    localparam int TID_W = 1, LINE_W = 12, CNT_W = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, req_pf = 0, cpl_valid = 0, cpl_write = 0;
    logic [TID_W-1:0] req_thread = '0;
    logic [1:0] req_kind = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LINE_W-1:0] cpl_line = '0;
    logic req_ready, iss_valid, iss_write, rsp_valid, pf_retire, proto_err, deadlock;
    logic [ADDR_W-1:0] iss_addr;
    logic [TID_W-1:0] iss_thread, rsp_thread;
    logic [1:0] rsp_kind;
    logic [TS_W-1:0] rsp_latency;
    logic [CNT_W-1:0] cnt_total, cnt_demand, cnt_pf;

    always #4 clk = ~clk;

    ot_miss_tracker #(.N_THR(N_THR), .N_ENT(N_ENT), .LINE_BYTES(LB), .ADDR_W(ADDR_W),
        .MAX_OUT(MAX_OUT), .TS_W(TS_W), .DL_THRESH(DL), .FWD_LAT(FWD)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_thread(req_thread),
        .req_kind(req_kind), .req_addr(req_addr), .req_pf(req_pf), .req_ready(req_ready),
        .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_thread(iss_thread),
        .iss_write(iss_write), .cpl_valid(cpl_valid), .cpl_line(cpl_line),
        .cpl_write(cpl_write), .rsp_valid(rsp_valid), .pf_retire(pf_retire),
        .rsp_thread(rsp_thread), .rsp_kind(rsp_kind), .rsp_latency(rsp_latency),
        .cnt_total(cnt_total), .cnt_demand(cnt_demand), .cnt_pf(cnt_pf),
        .proto_err(proto_err), .deadlock(deadlock));

    int n_chk = 0, n_bad = 0, cyc = 0;

    // reference model
    bit mv [N_THR][2][N_ENT];
    int ml [N_THR][2][N_ENT];
    int mk [N_THR][2][N_ENT];
    bit mpf[N_THR][2][N_ENT];
    int mts[N_THR][2][N_ENT];
    bit m_perr;
    bit iv [16];
    int ia [16], it [16], iw [16];

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_total(bit pf_only, bit dem_only);
        int n = 0;
        for (int t = 0; t < N_THR; t++)
            for (int w = 0; w < 2; w++)
                for (int e = 0; e < N_ENT; e++)
                    if (mv[t][w][e] && (!pf_only || mpf[t][w][e]) && (!dem_only || !mpf[t][w][e]))
                        n++;
        return n;
    endfunction

    task automatic do_reset();
        rst = 1'b1; req_valid = 0; cpl_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0; m_perr = 0;
        for (int t = 0; t < N_THR; t++)
            for (int w = 0; w < 2; w++)
                for (int e = 0; e < N_ENT; e++) mv[t][w][e] = 0;
        for (int s = 0; s < 16; s++) iv[s] = 0;
        #1;
        chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
        chk(cnt_total == 0 && cnt_demand == 0 && cnt_pf == 0, "R1 counts", cnt_total, 0);
        chk(!proto_err && !deadlock, "R1 flags", {proto_err, deadlock}, 0);
        chk(!rsp_valid && !pf_retire && !iss_valid, "R1 outputs",
            {rsp_valid, pf_retire, iss_valid}, 0);
    endtask

    // one cycle: drive at negedge, check ready, clock, check outputs at next negedge
    task automatic step(bit rv, int rt, int rk, int ra, bit rpf, bit cv, int cl, bit cw);
        int line, w, sidx, nfree, ct, ce, slot;
        bit same, confl, exp_rdy, hc, e_rsp, e_pf;
        int e_thr, e_kind, e_lat;
        req_valid = rv; req_thread = TID_W'(rt); req_kind = 2'(rk);
        req_addr = ADDR_W'(ra); req_pf = rpf;
        cpl_valid = cv; cpl_line = LINE_W'(cl); cpl_write = cw;
        #1;
        line = ra / LB; w = rk / 2;
        same = 0; confl = 0; sidx = 0; nfree = 0;
        for (int t = 0; t < N_THR; t++)
            for (int ww = 0; ww < 2; ww++)
                for (int e = 0; e < N_ENT; e++) begin
                    if (mv[t][ww][e] && ml[t][ww][e] == line) begin
                        if (t == rt && ww == w) begin same = 1; sidx = e; end
                        else confl = 1;
                    end
                    if (t == rt && ww == w && !mv[t][ww][e]) nfree++;
                end
        exp_rdy = (m_total(0, 0) < MAX_OUT) && !confl && (same || nfree > 0)
                  && !(cv && cl == line);
        chk(req_ready === exp_rdy, "R3 ready", req_ready, exp_rdy);
        hc = 0; ct = 0; ce = 0;
        for (int t = 0; t < N_THR; t++)
            for (int e = 0; e < N_ENT; e++)
                if (!hc && mv[t][cw][e] && ml[t][cw][e] == cl) begin hc = 1; ct = t; ce = e; end
        @(posedge clk);
        cyc++;
        e_rsp = 0; e_pf = 0; e_thr = 0; e_kind = 0; e_lat = 0;
        if (cv) begin
            if (hc) begin
                mv[ct][cw][ce] = 0;
                e_pf = mpf[ct][cw][ce]; e_rsp = !e_pf;
                e_thr = ct; e_kind = mk[ct][cw][ce]; e_lat = cyc - mts[ct][cw][ce];
            end else m_perr = 1;
        end
        if (rv && exp_rdy) begin
            if (!same) begin
                for (int e = 0; e < N_ENT; e++)
                    if (!same && !mv[rt][w][e] && !(hc && ct == rt && cw == w && ce == e)) begin
                        same = 1; sidx = e;
                    end
                slot = (cyc + FWD - 1) % 16;
                iv[slot] = 1; ia[slot] = line * LB; it[slot] = rt; iw[slot] = w;
            end
            mv[rt][w][sidx] = 1; ml[rt][w][sidx] = line; mk[rt][w][sidx] = rk;
            mpf[rt][w][sidx] = rpf; mts[rt][w][sidx] = cyc;
        end
        @(negedge clk);
        chk(rsp_valid === e_rsp, "R6 rsp_valid", rsp_valid, e_rsp);
        chk(pf_retire === e_pf, "R7 pf_retire", pf_retire, e_pf);
        if (e_rsp || e_pf) begin
            chk(rsp_thread == TID_W'(e_thr), "R6 thread", rsp_thread, e_thr);
            chk(rsp_kind == 2'(e_kind), "R2 kind", rsp_kind, e_kind);
            chk(rsp_latency == TS_W'(e_lat), "R6 latency", rsp_latency, e_lat);
        end
        slot = cyc % 16;
        chk(iss_valid === iv[slot], "R5 iss_valid", iss_valid, iv[slot]);
        if (iv[slot]) begin
            chk(iss_addr == ADDR_W'(ia[slot]), "R5 iss_addr", iss_addr, ia[slot]);
            chk(iss_thread == TID_W'(it[slot]) && iss_write == iw[slot], "R5 iss_tag",
                {iss_thread, iss_write}, it[slot] * 2 + iw[slot]);
        end
        iv[slot] = 0;
        chk(cnt_total == CNT_W'(m_total(0, 0)), "R9 total", cnt_total, m_total(0, 0));
        chk(cnt_pf == CNT_W'(m_total(1, 0)), "R9 prefetch", cnt_pf, m_total(1, 0));
        chk(cnt_demand == CNT_W'(m_total(0, 1)), "R9 demand", cnt_demand, m_total(0, 1));
        chk(proto_err === m_perr, "R8 proto_err", proto_err, m_perr);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int pre;
        void'($urandom(32'd24681));
        do_reset();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int t, w, e, cl; bit cv, cw;
            t = $urandom % N_THR; w = $urandom % 2; e = $urandom % N_ENT;
            cv = ($urandom % 2) == 1;
            if (mv[t][w][e] && ($urandom % 5) != 0) begin cl = ml[t][w][e]; cw = w; end
            else begin cl = $urandom % 10; cw = ($urandom % 2) == 1; end
            step(($urandom % 3) != 0, $urandom % N_THR, $urandom % 4,
                 ($urandom % 10) * LB + ($urandom % LB), ($urandom % 4) == 0, cv, cl, cw);
        end

        // directed: overwrite, conflict, kind routing, prefetch, limits
        do_reset();
        step(1, 0, 0, 16'h0123, 1, 0, 0, 0);           // prefetch load, new line
        step(1, 0, 0, 16'h0128, 0, 0, 0, 0);           // R4 overwrite to demand
        chk(cnt_total == 1 && cnt_pf == 0, "R4 overwrite count", cnt_total, 1);
        idle(3);
        step(1, 1, 1, 16'h0120, 0, 0, 0, 0);           // R3 other thread, same line
        step(1, 0, 2, 16'h0120, 0, 0, 0, 0);           // R3 same thread, write kind
        step(0, 0, 0, 0, 0, 1, 12'h012, 1);            // R2 write completion misses read entry
        chk(proto_err === 1'b1 && cnt_total == 1, "R2 R8 unmatched", proto_err, 1);
        step(0, 0, 0, 0, 0, 1, 12'h012, 0);            // R6 demand retire
        step(1, 1, 3, 16'h0405, 1, 0, 0, 0);           // atomic prefetch
        idle(5);
        step(0, 0, 0, 0, 0, 1, 12'h040, 1);            // R7 silent retire
        chk(proto_err === 1'b1, "R8 sticky", proto_err, 1);
        step(1, 0, 1, 16'h0500, 0, 0, 0, 0);
        step(1, 1, 2, 16'h0600, 0, 1, 12'h050, 0);     // R9 accept + retire same edge
        chk(cnt_total == 1, "R9 same-cycle", cnt_total, 1);
        step(0, 0, 0, 0, 0, 1, 12'h060, 1);
        // fill to the global limit
        for (int k = 0; k < 3; k++) step(1, 0, 0, 16'h0700 + k * LB, 0, 0, 0, 0);
        for (int k = 0; k < 3; k++) step(1, 1, 2, 16'h0800 + k * LB, 0, 0, 0, 0);
        chk(cnt_total == MAX_OUT, "R3 full", cnt_total, MAX_OUT);
        step(1, 1, 0, 16'h0900, 0, 0, 0, 0);           // R3 refused at limit
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 1, 12'h070 + k, 0);
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 1, 12'h080 + k, 1);

        // watchdog
        do_reset();
        step(1, 0, 0, 16'h0A00, 0, 0, 0, 0);
        idle(20);
        step(0, 0, 0, 0, 0, 1, 12'h0A0, 0);
        idle(3 * DL);
        chk(deadlock === 1'b0, "R10 no deadlock", deadlock, 0);
        step(1, 1, 2, 16'h0B00, 0, 0, 0, 0);
        idle(3 * DL);
        chk(deadlock === 1'b1, "R10 deadlock", deadlock, 1);
        pre = n_bad;
        step(0, 0, 0, 0, 0, 1, 12'h0B0, 1);
        idle(2);
        chk(deadlock === 1'b1, "R10 sticky", deadlock, 1);
        if (n_bad != pre) $display("directed watchdog section had mismatches");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule